// File: doc/BRIEF.md
# Twelve-Bit Coefficient Byte Packer

This block turns polynomials of 256 twelve-bit coefficients into a densely packed byte stream. Two neighbouring coefficients (an even one, c0, and the odd one after it, c1) share 24 bits, so each pair becomes exactly three bytes. The coefficients sit in two single-port RAMs that both return data one cycle after the address is presented. The lower polynomial indices are held in the first RAM and the remaining ones in the second, and each RAM is addressed with the polynomial's index inside its own group. The packed bytes leave through a write port that carries a byte address, a byte of data and a write enable.

A one-cycle `start_i` pulse in the idle state launches a full pass over all polynomials. Every pair costs a fixed four cycles: a fetch-only cycle followed by three write cycles. The nibble and byte that belong to the next write are held in small registers between cycles. When the final byte of the last polynomial has been written, `done_o` pulses for one cycle and the block returns to idle.

The controller has three states. IDLE waits for start. RUN steps through phase, pair and polynomial. FIN raises done for one cycle. The transitions are: IDLE to RUN on start, RUN to FIN after the third write of the last pair of the last polynomial, and FIN back to IDLE unconditionally.

Top module: `coef_byte_packer`

## Requirements
- R1: While reset is asserted and after reset is released, the block is idle: `wr_en_o` and `done_o` are 0.
- R2: A start seen in IDLE moves the block to RUN. The first RUN cycle is phase 0 of pair 0 of polynomial 0, and it performs no write.
- R3: In phase 1 the written byte is c0[7:0].
- R4: In phase 2 the written byte is {c1[3:0], c0[11:8]}. The upper four bits of c0 are kept from phase 1.
- R5: In phase 3 the written byte is c1[11:4]. This value is kept from the read data seen in phase 2.
- R6: The write address is poly*384 + pair*3 + (phase-1).
- R7: Polynomials with index below SPLIT are read from RAM A at local index poly. All others are read from RAM B at local index poly-SPLIT. The read address is local*256 + 2*pair in phase 0 and local*256 + 2*pair + 1 in phase 1. The data is used in the following cycle.
- R8: Each pair takes exactly four cycles, with phases 0,1,2,3 in that order and a write in phases 1 to 3 only. Pairs advance 0 to 127 within a polynomial, then the polynomial index advances.
- R9: In the cycle after the last byte, `done_o` is 1 for exactly one cycle with `wr_en_o` at 0. `wr_en_o` then stays 0 until the next start.
- R10: A start asserted during RUN or FIN is ignored. A pass always lasts NUM_POLY*512 RUN cycles, followed by one FIN cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | Begin a pass (honoured in IDLE only) |
| done_o | output | 1 | One-cycle pulse after the final byte |
| ram_a_addr_o | output | RD_AW | Read address for RAM A (0 when RAM B is in use) |
| ram_a_data_i | input | 12 | RAM A read data, one cycle after the address |
| ram_b_addr_o | output | RD_AW | Read address for RAM B (0 when RAM A is in use) |
| ram_b_data_i | input | 12 | RAM B read data, one cycle after the address |
| wr_en_o | output | 1 | Byte write enable |
| wr_addr_o | output | WR_AW | Byte write address |
| wr_data_o | output | 8 | Packed byte |

## Verification
The bench builds the block with NUM_POLY=3 and SPLIT=1. With these values the two groups are of unequal size, and RAM B holds two polynomials, so a non-zero local polynomial index and the poly-SPLIT subtraction are both exercised. A polynomial count that is not a power of two tests the final-polynomial detection and the wrap of the polynomial counter. Write addresses cross two 384-byte polynomial boundaries. The coefficient patterns include all-ones and all-zeros values, which expose any misplaced nibble in the middle byte.

// File: rtl/cbp_pkg.sv
package cbp_pkg;
    localparam int COEFS      = 256;
    localparam int PAIRS      = COEFS / 2;
    localparam int PAIR_W     = $clog2(PAIRS);
    localparam int POLY_BYTES = PAIRS * 3;
    localparam int COEF_W     = 12;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_RUN  = 2'd1,
        ST_FIN  = 2'd2
    } cbp_state_e;
endpackage

// File: rtl/cbp_seq.sv
module cbp_seq
    import cbp_pkg::*;
#(
    parameter int NUM_POLY = 4,
    parameter int POLY_W   = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    output cbp_state_e        state,
    output logic [1:0]        phase,
    output logic [PAIR_W-1:0] pair,
    output logic [POLY_W-1:0] poly
);
    cbp_state_e state_d;
    logic       pair_end;
    logic       last_step;

    assign pair_end  = (pair == PAIR_W'(PAIRS - 1));
    assign last_step = (phase == 2'd3) && pair_end && (poly == POLY_W'(NUM_POLY - 1));

    // next-state decode
    always_comb begin
        state_d = state;
        unique case (state)
            ST_IDLE: if (start)     state_d = ST_RUN;
            ST_RUN:  if (last_step) state_d = ST_FIN;
            ST_FIN:                 state_d = ST_IDLE;
            default:                state_d = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_d;
    end

    // phase / pair / polynomial counters
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase <= 2'd0;
            pair  <= '0;
            poly  <= '0;
        end else if (state == ST_IDLE && start) begin
            phase <= 2'd0;
            pair  <= '0;
            poly  <= '0;
        end else if (state == ST_RUN) begin
            phase <= phase + 2'd1;
            if (phase == 2'd3) begin
                pair <= pair + 1'b1;
                if (pair_end) poly <= last_step ? '0 : poly + 1'b1;
            end
        end
    end
endmodule

// File: rtl/cbp_addr.sv
module cbp_addr
    import cbp_pkg::*;
#(
    parameter int NUM_POLY = 4,
    parameter int SPLIT    = 2,
    parameter int POLY_W   = 2,
    parameter int RD_AW    = 10,
    parameter int WR_AW    = 11
) (
    input  logic [1:0]        phase,
    input  logic [PAIR_W-1:0] pair,
    input  logic [POLY_W-1:0] poly,
    output logic              use_b,
    output logic [RD_AW-1:0]  rd_addr_a,
    output logic [RD_AW-1:0]  rd_addr_b,
    output logic [WR_AW-1:0]  wr_addr
);
    logic [POLY_W-1:0] local_poly;
    logic              half;
    logic [RD_AW-1:0]  rd_addr;

    always_comb begin
        use_b      = (int'(poly) >= SPLIT);
        local_poly = use_b ? (poly - POLY_W'(SPLIT)) : poly;
        half       = (phase != 2'd0);            // c0 in phase 0, c1 afterwards
        rd_addr    = RD_AW'({local_poly, pair, half});
        rd_addr_a  = use_b ? '0 : rd_addr;
        rd_addr_b  = use_b ? rd_addr : '0;
        wr_addr    = WR_AW'(poly) * WR_AW'(POLY_BYTES)
                   + WR_AW'(pair) * WR_AW'(3)
                   + WR_AW'(phase - 2'd1);
    end
endmodule

// File: rtl/cbp_bytes.sv
module cbp_bytes
    import cbp_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              active,
    input  logic [1:0]        phase,
    input  logic [COEF_W-1:0] coef,
    output logic [7:0]        byte_o
);
    logic [3:0] c0_top;   // c0[11:8], held for the middle byte
    logic [7:0] c1_top;   // c1[11:4], held for the last byte

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            c0_top <= '0;
            c1_top <= '0;
        end else if (active) begin
            if (phase == 2'd1) c0_top <= coef[11:8];
            if (phase == 2'd2) c1_top <= coef[11:4];
        end
    end

    always_comb begin
        unique case (phase)
            2'd1:    byte_o = coef[7:0];
            2'd2:    byte_o = {coef[3:0], c0_top};
            default: byte_o = c1_top;
        endcase
    end
endmodule

// File: rtl/coef_byte_packer.sv
module coef_byte_packer
    import cbp_pkg::*;
#(
    parameter int NUM_POLY = 4,
    parameter int SPLIT    = 2,
    localparam int POLY_W  = (NUM_POLY > 1) ? $clog2(NUM_POLY) : 1,
    localparam int RD_AW   = POLY_W + $clog2(COEFS),
    localparam int WR_AW   = $clog2(NUM_POLY * POLY_BYTES)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    output logic              done_o,
    output logic [RD_AW-1:0]  ram_a_addr_o,
    input  logic [COEF_W-1:0] ram_a_data_i,
    output logic [RD_AW-1:0]  ram_b_addr_o,
    input  logic [COEF_W-1:0] ram_b_data_i,
    output logic              wr_en_o,
    output logic [WR_AW-1:0]  wr_addr_o,
    output logic [7:0]        wr_data_o
);
    cbp_state_e        state;
    logic [1:0]        phase;
    logic [PAIR_W-1:0] pair;
    logic [POLY_W-1:0] poly;
    logic              use_b;
    logic [COEF_W-1:0] coef_sel;

    cbp_seq #(.NUM_POLY(NUM_POLY), .POLY_W(POLY_W)) seq_i (
        .clk   (clk),
        .rst_n (rst_n),
        .start (start_i),
        .state (state),
        .phase (phase),
        .pair  (pair),
        .poly  (poly)
    );

    cbp_addr #(
        .NUM_POLY (NUM_POLY),
        .SPLIT    (SPLIT),
        .POLY_W   (POLY_W),
        .RD_AW    (RD_AW),
        .WR_AW    (WR_AW)
    ) addr_i (
        .phase     (phase),
        .pair      (pair),
        .poly      (poly),
        .use_b     (use_b),
        .rd_addr_a (ram_a_addr_o),
        .rd_addr_b (ram_b_addr_o),
        .wr_addr   (wr_addr_o)
    );

    // poly is unchanged from the fetch cycle to the use cycle, so the
    // current group select lines up with the one-cycle RAM latency.
    assign coef_sel = use_b ? ram_b_data_i : ram_a_data_i;

    cbp_bytes bytes_i (
        .clk    (clk),
        .rst_n  (rst_n),
        .active (state == ST_RUN),
        .phase  (phase),
        .coef   (coef_sel),
        .byte_o (wr_data_o)
    );

    // output decode
    always_comb begin
        wr_en_o = (state == ST_RUN) && (phase != 2'd0);
        done_o  = (state == ST_FIN);
    end
endmodule

// File: rtl/cbp_chk.sv
module cbp_chk
    import cbp_pkg::*;
#(
    parameter int WR_AW = 11
) (
    input logic              clk,
    input logic              rst_n,
    input logic              start_i,
    input cbp_state_e        state,
    input logic [1:0]        phase,
    input logic [PAIR_W-1:0] pair,
    input logic [COEF_W-1:0] coef_sel,
    input logic              wr_en_o,
    input logic [WR_AW-1:0]  wr_addr_o,
    input logic [7:0]        wr_data_o,
    input logic              done_o
);
    assert_idle_in_reset_R1: assert property (@(posedge clk)
        !rst_n |=> (!wr_en_o && !done_o));

    assert_first_cycle_silent_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_IDLE && start_i) |=> (!wr_en_o && state == ST_RUN));

    assert_mid_byte_carry_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_RUN && phase == 2'd2) |-> (wr_data_o[3:0] == $past(coef_sel[11:8])));

    assert_last_byte_carry_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_RUN && phase == 2'd3) |-> (wr_data_o == $past(coef_sel[11:4])));

    assert_addr_contiguous_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en_o && $past(wr_en_o)) |-> (wr_addr_o == $past(wr_addr_o) + 1'b1));

    assert_pair_advance_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_RUN && phase == 2'd3 && pair != PAIR_W'(PAIRS - 1))
        |=> (phase == 2'd0 && pair == $past(pair) + 1'b1));

    assert_done_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> (!done_o && !wr_en_o));

    assert_done_no_write_R9: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> !wr_en_o);
endmodule

bind coef_byte_packer cbp_chk #(.WR_AW(WR_AW)) chk_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .start_i   (start_i),
    .state     (state),
    .phase     (phase),
    .pair      (pair),
    .coef_sel  (coef_sel),
    .wr_en_o   (wr_en_o),
    .wr_addr_o (wr_addr_o),
    .wr_data_o (wr_data_o),
    .done_o    (done_o)
);

// File: tb/coef_byte_packer_tb_top.sv
module coef_byte_packer_tb_top;
    localparam int NP    = 3;
    localparam int SP    = 1;
    localparam int TOTAL = NP * 512;
    localparam int RAW   = 10;
    localparam int WAW   = 11;

    logic           clk = 1'b0;
    logic           rst_n;
    logic           start;
    logic           done;
    logic [RAW-1:0] ra, rb;
    logic [11:0]    rd_a, rd_b;
    logic           we;
    logic [WAW-1:0] waddr;
    logic [7:0]     wdata;

    int checks   = 0;
    int failures = 0;
    bit run_chk  = 0;
    int mcyc     = -1;
    logic [11:0] mem_a [0:1023];
    logic [11:0] mem_b [0:1023];

    always #2.5 clk = ~clk;

    coef_byte_packer #(.NUM_POLY(NP), .SPLIT(SP)) dut_i (
        .clk          (clk),
        .rst_n        (rst_n),
        .start_i      (start),
        .done_o       (done),
        .ram_a_addr_o (ra),
        .ram_a_data_i (rd_a),
        .ram_b_addr_o (rb),
        .ram_b_data_i (rd_b),
        .wr_en_o      (we),
        .wr_addr_o    (waddr),
        .wr_data_o    (wdata)
    );

    // RAM models: one-cycle registered read
    always @(posedge clk) begin
        rd_a <= mem_a[ra];
        rd_b <= mem_b[rb];
    end

    // reference model: cycle index within a pass (-1 idle, TOTAL = done cycle)
    always @(posedge clk) begin
        if (!rst_n)            mcyc <= -1;
        else if (mcyc < 0)     begin if (start) mcyc <= 0; end
        else if (mcyc == TOTAL) mcyc <= -1;
        else                   mcyc <= mcyc + 1;
    end

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    function automatic logic [11:0] coef(input int p, input int i);
        if (p < SP) return mem_a[p * 256 + i];
        return mem_b[(p - SP) * 256 + i];
    endfunction

    task automatic fill(input int mode);
        for (int i = 0; i < 1024; i++) begin
            if (mode == 0) begin
                mem_a[i] = 12'((i * 2731 + 977) ^ (i >> 2));
                mem_b[i] = 12'((i * 1543) ^ 12'h5A3);
            end else if (mode == 1) begin
                mem_a[i] = 12'((i * 3001 + 41) ^ 12'hC0F);
                mem_b[i] = 12'((i * 61 + 7) ^ (i << 3));
            end else begin
                mem_a[i] = (i % 2 == 0) ? 12'hFFF : 12'h000;
                mem_b[i] = (i % 4 < 2) ? 12'h000 : 12'hFFF;
            end
        end
    endtask

    // per-cycle comparison against the model
    always @(negedge clk) begin
        if (run_chk) begin
            int  ph, pr, po, loc, eaddr;
            bit  ewe, edone;
            logic [11:0] c0, c1;
            logic [7:0]  eb;
            ewe   = (mcyc >= 0) && (mcyc < TOTAL) && (mcyc % 4 != 0);
            edone = (mcyc == TOTAL);
            ph = (mcyc < 0) ? 0 : mcyc % 4;
            pr = (mcyc < 0) ? 0 : (mcyc / 4) % 128;
            po = (mcyc < 0) ? 0 : mcyc / 512;
            if (mcyc == 0)      chk(we == 1'b0, "R2", we, 0);
            else if (mcyc < 0)  chk(we == 1'b0, "R9", we, 0);
            else                chk(we == ewe, "R8", we, ewe);
            chk(done == edone, "R9", done, edone);
            if (ewe) begin
                c0 = coef(po, 2 * pr);
                c1 = coef(po, 2 * pr + 1);
                eaddr = po * 384 + pr * 3 + ph - 1;
                chk(int'(waddr) == eaddr, "R6", waddr, eaddr);
                if (ph == 1) begin
                    eb = c0[7:0];
                    chk(wdata == eb, "R3", wdata, eb);
                end else if (ph == 2) begin
                    eb = {c1[3:0], c0[11:8]};
                    chk(wdata == eb, "R4", wdata, eb);
                end else begin
                    eb = c1[11:4];
                    chk(wdata == eb, "R5", wdata, eb);
                end
            end
            if (mcyc >= 0 && mcyc < TOTAL && ph <= 1) begin
                loc = (po < SP) ? po : po - SP;
                eaddr = loc * 256 + 2 * pr + ph;
                if (po < SP) chk(int'(ra) == eaddr, "R7", ra, eaddr);
                else         chk(int'(rb) == eaddr, "R7", rb, eaddr);
            end
        end
    end

    task automatic finish_tb();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    endtask

    initial begin
        repeat (60000) @(posedge clk);
        failures++;
        $display("FAIL watchdog expired");
        finish_tb();
    end

    initial begin
        int n;
        rst_n = 1'b0;
        start = 1'b0;
        fill(0);
        repeat (3) @(negedge clk);
        chk(we == 1'b0 && done == 1'b0, "R1", {we, done}, 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(we == 1'b0 && done == 1'b0, "R1", {we, done}, 0);
        run_chk = 1;

        // pass 1: plain pulse
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        while (!done) @(negedge clk);
        repeat (10) @(negedge clk);

        // pass 2: extra start pulse mid-run must be ignored (R10)
        fill(1);
        start = 1'b1;
        n = 0;
        do begin
            @(negedge clk);
            n++;
            start = (n == 700);
        end while (!done);
        chk(n == TOTAL + 1, "R10", n, TOTAL + 1);
        repeat (6) @(negedge clk);

        // pass 3: extreme values, start held for several cycles (R10)
        fill(2);
        start = 1'b1;
        repeat (4) @(negedge clk);
        start = 1'b0;
        while (!done) @(negedge clk);
        repeat (12) @(negedge clk);
        chk(we == 1'b0 && done == 1'b0, "R9", {we, done}, 0);
        finish_tb();
    end
endmodule